// File: doc/BRIEF.md
# Three-Phase Complementary PWM Compare Stage

This block generates three pairs of complementary pulse-width-modulated outputs from one triangular carrier. An up/down counter rises from zero to a programmable peak and falls back to zero. Each phase compares the counter with its own threshold and switches its two outputs whenever the two are equal. Which of the pair turns on depends on the direction of the count.

Software never writes a threshold directly. It writes a visible staging register. A hidden middle register sits between that staging register and the live threshold. A window of N clocks ends at each enabled turning point of the carrier. Inside that window the middle register is frozen and serves as the threshold. At the turning point it is promoted to the live threshold. An update mode input selects the turning points that promote: the peak, the trough, both, or neither. The peak also has a staging register. Its value is taken over at each trough, or at once while the counter is halted.

Top module: `cpwm_unit`

## Requirements
- R1: On synchronous active-high reset, every register is zero, the counter is 0 and counting up, and all six outputs are at their inactive level, which is 0 when the polarity bits are zero.
- R2: With a nonzero active peak P, the counter steps by one each clock through 0,1,...,P,P-1,...,1,0,1,... and `cnt_up` is 1 exactly while it rises. The cycle at value P while rising is the peak point. The cycle at value 0 while falling is the trough point.
- R3: The active peak loads from the peak staging register at every trough point. It also loads on every clock while the active peak is zero. While the active peak is zero, the counter is held at 0, counting up, and no phase compares.
- R4: Register port, with writes on `wr_en` and reads combinational on `rd_addr`. Address 0..2 is the phase 0..2 staging register. Address 3 is the peak staging register. Address 4 holds the polarity bits: bit 0 for the positive side, bit 1 for the negative side. Address 5 is the window length N. Every other address reads 0 and ignores writes, and the hidden registers have no address.
- R5: Outside the window, on every clock the hidden register takes the value the staging register held before that clock edge.
- R6: The window holds on a clock when the peak is nonzero and one of two conditions is met. Either the counter is rising, `upd_mode` bit 0 is set, and P minus the counter is less than N. Or the counter is falling, `upd_mode` bit 1 is set, and the counter is less than N. Inside the window the hidden register holds its value.
- R7: At a peak point with `upd_mode` bit 0 set, or at a trough point with `upd_mode` bit 1 set, the live threshold takes the hidden register's value.
- R8: Inside the window the hidden register is the value compared with the counter. Outside it, the live threshold is compared.
- R9: On an equal compare while rising, the phase's positive side goes active and its negative side inactive. While falling, the reverse happens. The outputs change on the clock after the compare.
- R10: Each output pin equals its active state XOR its polarity bit, and a polarity write takes effect on the next cycle.
- R11: With `upd_mode` = 00 the live thresholds never change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 16 | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | 16 | Read data, combinational |
| upd_mode | input | 2 | Bit 0 enables promotion at the peak, bit 1 at the trough |
| cnt | output | 16 | Carrier counter |
| cnt_up | output | 1 | 1 while the carrier rises |
| pwm_p | output | 3 | Positive-side outputs, one per phase |
| pwm_n | output | 3 | Negative-side outputs, one per phase |

## Verification
The interesting collision is a staging-register write that lands on the same clock edge as a turning point. On that edge the hidden register is frozen and is being promoted to the live threshold. The bench waits for the counter to sit on the peak value and issues the write on exactly that edge. It also issues staging writes at a steady pace, whose phase against the carrier drifts, so many writes fall inside or at the edge of the window. A behavioural model, advanced on every clock, predicts the outputs. A write that slips into the hidden or live register a cycle early or late shows up as a shifted output edge.

// File: rtl/cpwm_pkg.sv
package cpwm_pkg;

    // bit positions inside the update mode input
    localparam int SEL_PEAK   = 0;
    localparam int SEL_TROUGH = 1;
    localparam int MODE_W     = 2;

    // per-cycle view of the carrier handed to each phase
    typedef struct packed {
        logic run;   // active peak nonzero
        logic up;    // rising
        logic tb;    // hold window in progress
        logic xfer;  // promote hidden -> live this cycle
    } turn_t;

    typedef struct packed {
        logic pol_n;
        logic pol_p;
    } pol_t;

    function automatic logic promote(input logic [MODE_W-1:0] mode,
                                     input logic pk_evt,
                                     input logic tr_evt);
        return (pk_evt && mode[SEL_PEAK]) || (tr_evt && mode[SEL_TROUGH]);
    endfunction

endpackage

// File: rtl/cpwm_regs.sv
module cpwm_regs
    import cpwm_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int NPH   = 3,
    parameter int AW    = 3
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      wr_en,
    input  logic [AW-1:0]             wr_addr,
    input  logic [CNT_W-1:0]          wr_data,
    input  logic [AW-1:0]             rd_addr,
    output logic [CNT_W-1:0]          rd_data,
    output logic [NPH-1:0][CNT_W-1:0] stage,
    output logic [CNT_W-1:0]          peak_stage,
    output logic [CNT_W-1:0]          win_len,
    output pol_t                      pol
);
    localparam int A_PEAK = NPH;
    localparam int A_POL  = NPH + 1;
    localparam int A_WIN  = NPH + 2;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage      <= '0;
            peak_stage <= '0;
            win_len    <= '0;
            pol        <= '0;
        end else if (wr_en) begin
            for (int i = 0; i < NPH; i++) begin
                if (wr_addr == AW'(i)) stage[i] <= wr_data;
            end
            if (wr_addr == AW'(A_PEAK)) peak_stage <= wr_data;
            if (wr_addr == AW'(A_POL))  pol        <= pol_t'(wr_data[1:0]);
            if (wr_addr == AW'(A_WIN))  win_len    <= wr_data;
        end
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NPH; i++) begin
            if (rd_addr == AW'(i)) rd_data = stage[i];
        end
        if (rd_addr == AW'(A_PEAK)) rd_data = peak_stage;
        if (rd_addr == AW'(A_POL))  rd_data = CNT_W'(pol);
        if (rd_addr == AW'(A_WIN))  rd_data = win_len;
    end
endmodule

// File: rtl/cpwm_carrier.sv
module cpwm_carrier
    import cpwm_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CNT_W-1:0]  peak_stage,
    input  logic [CNT_W-1:0]  win_len,
    input  logic [MODE_W-1:0] mode,
    output logic [CNT_W-1:0]  cnt,
    output logic [CNT_W-1:0]  peak_act,
    output turn_t             turn
);
    logic             up;
    logic             run;
    logic             pk_evt;
    logic             tr_evt;
    logic [CNT_W-1:0] to_peak;
    logic             near_pk;
    logic             near_tr;

    always_comb begin
        run     = (peak_act != '0);
        pk_evt  = run && up && (cnt == peak_act);
        tr_evt  = run && !up && (cnt == '0);
        to_peak = peak_act - cnt;
        near_pk = up && mode[SEL_PEAK] && (to_peak < win_len);
        near_tr = !up && mode[SEL_TROUGH] && (cnt < win_len);
        turn.run  = run;
        turn.up   = up;
        turn.tb   = run && (near_pk || near_tr);
        turn.xfer = promote(mode, pk_evt, tr_evt);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt      <= '0;
            up       <= 1'b1;
            peak_act <= '0;
        end else if (!run) begin
            cnt      <= '0;
            up       <= 1'b1;
            peak_act <= peak_stage;
        end else if (pk_evt) begin
            cnt <= cnt - 1'b1;
            up  <= 1'b0;
        end else if (tr_evt) begin
            cnt      <= cnt + 1'b1;
            up       <= 1'b1;
            peak_act <= peak_stage;
        end else if (up) begin
            cnt <= cnt + 1'b1;
        end else begin
            cnt <= cnt - 1'b1;
        end
    end
endmodule

// File: rtl/cpwm_phase.sv
module cpwm_phase
    import cpwm_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] stage,
    input  logic [CNT_W-1:0] cnt,
    input  turn_t            turn,
    output logic [CNT_W-1:0] hold,
    output logic [CNT_W-1:0] live,
    output logic             p_on,
    output logic             n_on
);
    logic [CNT_W-1:0] thr;
    logic             hit;

    always_comb begin
        thr = turn.tb ? hold : live;
        hit = turn.run && (cnt == thr);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hold <= '0;
            live <= '0;
            p_on <= 1'b0;
            n_on <= 1'b0;
        end else begin
            if (!turn.tb)  hold <= stage;
            if (turn.xfer) live <= hold;
            if (hit) begin
                p_on <= turn.up;
                n_on <= !turn.up;
            end
        end
    end
endmodule

// File: rtl/cpwm_unit.sv
module cpwm_unit
    import cpwm_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int NPH   = 3,
    parameter int AW    = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    input  logic [AW-1:0]     rd_addr,
    output logic [CNT_W-1:0]  rd_data,
    input  logic [MODE_W-1:0] upd_mode,
    output logic [CNT_W-1:0]  cnt,
    output logic              cnt_up,
    output logic [NPH-1:0]    pwm_p,
    output logic [NPH-1:0]    pwm_n
);
    logic [NPH-1:0][CNT_W-1:0] stage;
    logic [NPH-1:0][CNT_W-1:0] hold_all;
    logic [NPH-1:0][CNT_W-1:0] live_all;
    logic [CNT_W-1:0]          peak_stage;
    logic [CNT_W-1:0]          peak_act;
    logic [CNT_W-1:0]          win_len;
    logic [NPH-1:0]            p_on;
    logic [NPH-1:0]            n_on;
    logic                      in_win;
    pol_t                      pol;
    turn_t                     turn;

    cpwm_regs #(.CNT_W(CNT_W), .NPH(NPH), .AW(AW)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .rd_addr    (rd_addr),
        .rd_data    (rd_data),
        .stage      (stage),
        .peak_stage (peak_stage),
        .win_len    (win_len),
        .pol        (pol)
    );

    cpwm_carrier #(.CNT_W(CNT_W)) u_carrier (
        .clk        (clk),
        .rst        (rst),
        .peak_stage (peak_stage),
        .win_len    (win_len),
        .mode       (upd_mode),
        .cnt        (cnt),
        .peak_act   (peak_act),
        .turn       (turn)
    );

    for (genvar g = 0; g < NPH; g++) begin : g_phase
        cpwm_phase #(.CNT_W(CNT_W)) u_phase (
            .clk   (clk),
            .rst   (rst),
            .stage (stage[g]),
            .cnt   (cnt),
            .turn  (turn),
            .hold  (hold_all[g]),
            .live  (live_all[g]),
            .p_on  (p_on[g]),
            .n_on  (n_on[g])
        );
        assign pwm_p[g] = p_on[g] ^ pol.pol_p;
        assign pwm_n[g] = n_on[g] ^ pol.pol_n;
    end

    assign cnt_up = turn.up;
    assign in_win = turn.tb;
endmodule

// File: rtl/cpwm_unit_chk.sv
module cpwm_unit_chk #(
    parameter int CNT_W = 16,
    parameter int NPH   = 3
) (
    input logic                      clk,
    input logic                      rst,
    input logic [1:0]                upd_mode,
    input logic [CNT_W-1:0]          cnt,
    input logic                      cnt_up,
    input logic [CNT_W-1:0]          peak_act,
    input logic                      in_win,
    input logic [NPH-1:0][CNT_W-1:0] hold_all,
    input logic [NPH-1:0][CNT_W-1:0] live_all,
    input logic [NPH-1:0]            p_on,
    input logic [NPH-1:0]            n_on
);
    a_r2_climb: assert property (@(posedge clk) disable iff (rst)
        (peak_act != '0 && cnt_up && cnt != peak_act) |=> (cnt == $past(cnt) + CNT_W'(1)));

    a_r2_turn_down: assert property (@(posedge clk) disable iff (rst)
        (peak_act != '0 && cnt_up && cnt == peak_act) |=> !cnt_up);

    a_r3_peak_hold: assert property (@(posedge clk) disable iff (rst)
        (peak_act != '0 && !(!cnt_up && cnt == '0)) |=> $stable(peak_act));

    a_r6_hold_frozen: assert property (@(posedge clk) disable iff (rst)
        in_win |=> $stable(hold_all));

    a_r11_no_promote: assert property (@(posedge clk) disable iff (rst)
        (upd_mode == 2'b00) |=> $stable(live_all));

    a_r9_exclusive: assert property (@(posedge clk) disable iff (rst)
        (p_on & n_on) == '0);
endmodule

bind cpwm_unit cpwm_unit_chk #(.CNT_W(CNT_W), .NPH(NPH)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .upd_mode (upd_mode),
    .cnt      (cnt),
    .cnt_up   (cnt_up),
    .peak_act (peak_act),
    .in_win   (in_win),
    .hold_all (hold_all),
    .live_all (live_all),
    .p_on     (p_on),
    .n_on     (n_on)
);

// File: tb/cpwm_unit_bench.sv
module cpwm_unit_bench;
    localparam int PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [2:0]  rd_addr = '0;
    logic [15:0] rd_data;
    logic [1:0]  upd_mode = 2'b11;
    logic [15:0] cnt;
    logic        cnt_up;
    logic [2:0]  pwm_p;
    logic [2:0]  pwm_n;

    int nchk = 0;
    int nerr = 0;
    int cycles = 0;
    bit started = 0;
    int seed = 12345;

    // reference model state
    int m_cnt, m_up, m_pk, m_pkbuf, m_n, m_polp, m_poln;
    int m_buf[3], m_tmp[3], m_cmp[3];
    int m_pon[3], m_non[3];
    int run, pke, tre, win, xf, eff;

    cpwm_unit u_cpwm_unit (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .upd_mode(upd_mode),
        .cnt(cnt), .cnt_up(cnt_up), .pwm_p(pwm_p), .pwm_n(pwm_n)
    );

    always #(PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int model_rd(input int a);
        if (a < 3)  return m_buf[a];
        if (a == 3) return m_pkbuf;
        if (a == 4) return m_poln * 2 + m_polp;
        if (a == 5) return m_n;
        return 0;
    endfunction

    function automatic int pins(input int pol, input bit side_p);
        int v = 0;
        for (int i = 0; i < 3; i++) begin
            v |= (((side_p ? m_pon[i] : m_non[i]) ^ pol) & 1) << i;
        end
        return v;
    endfunction

    // behavioural reference, advanced on every clock
    always @(posedge clk) begin
        if (rst) begin
            m_cnt = 0; m_up = 1; m_pk = 0; m_pkbuf = 0; m_n = 0; m_polp = 0; m_poln = 0;
            for (int i = 0; i < 3; i++) begin
                m_buf[i] = 0; m_tmp[i] = 0; m_cmp[i] = 0; m_pon[i] = 0; m_non[i] = 0;
            end
            started = 1;
        end else begin
            run = (m_pk != 0);
            pke = run && m_up && m_cnt == m_pk;
            tre = run && !m_up && m_cnt == 0;
            win = run && ((m_up && upd_mode[0] && (m_pk - m_cnt) < m_n) ||
                          (!m_up && upd_mode[1] && m_cnt < m_n));
            xf  = (pke && upd_mode[0]) || (tre && upd_mode[1]);
            for (int i = 0; i < 3; i++) begin
                eff = win ? m_tmp[i] : m_cmp[i];
                if (run && m_cnt == eff) begin
                    m_pon[i] = m_up; m_non[i] = !m_up;
                end
                if (xf)   m_cmp[i] = m_tmp[i];
                if (!win) m_tmp[i] = m_buf[i];
            end
            if (!run) begin
                m_cnt = 0; m_up = 1; m_pk = m_pkbuf;
            end else if (pke) begin
                m_cnt--; m_up = 0;
            end else if (tre) begin
                m_cnt++; m_up = 1; m_pk = m_pkbuf;
            end else if (m_up) begin
                m_cnt++;
            end else begin
                m_cnt--;
            end
            if (wr_en) begin
                if (wr_addr < 3) m_buf[wr_addr] = wr_data;
                else if (wr_addr == 3) m_pkbuf = wr_data;
                else if (wr_addr == 4) begin m_polp = wr_data[0]; m_poln = wr_data[1]; end
                else if (wr_addr == 5) m_n = wr_data;
            end
        end
    end

    // read address sweeps all eight addresses
    always @(negedge clk) rd_addr <= rd_addr + 3'd1;

    // comparison against the model and watchdog
    always @(negedge clk) begin
        #1;
        cycles++;
        if (started) begin
            check(cnt == m_cnt[15:0], "R2 counter value", cnt, m_cnt);
            check(cnt_up == m_up[0], "R2 direction flag", cnt_up, m_up);
            check(pwm_p == pins(m_polp, 1), "R5/R6/R7/R8/R9/R10/R11 positive pins", pwm_p, pins(m_polp, 1));
            check(pwm_n == pins(m_poln, 0), "R5/R6/R7/R8/R9/R10/R11 negative pins", pwm_n, pins(m_poln, 0));
            check(rd_data == model_rd(rd_addr), "R4 read data", rd_data, model_rd(rd_addr));
        end
        if (cycles > 60000) begin
            check(0, "watchdog", cycles, 60000);
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    task automatic wr(input int a, input int d);
        wr_en = 1'b1; wr_addr = a[2:0]; wr_data = d[15:0];
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic churn(input int n, input int limit);
        for (int k = 0; k < n; k++) begin
            seed = (seed * 1103515245 + 12345) & 32'h7fffffff;
            if (k % 5 == 0) wr(k % 3, (seed >> 8) % limit);
            else if (k % 97 == 0) wr(4, (seed >> 4) & 3);
            else step(1);
        end
    endtask

    initial begin
        int mx;
        step(3);
        #1;
        check(cnt == 0 && cnt_up == 1'b1, "R1 counter at reset", cnt, 0);
        check(pwm_p == 0 && pwm_n == 0, "R1 outputs at reset", {pwm_p, pwm_n}, 0);
        rst = 1'b0;
        step(1);
        wr(5, 3); wr(0, 4); wr(1, 9); wr(2, 14); wr(3, 16);
        upd_mode = 2'b11;
        step(40);
        mx = 0;
        for (int k = 0; k < 70; k++) begin
            @(negedge clk); #1;
            if (cnt > mx) mx = cnt;
        end
        check(mx == 16, "R3 carrier peak", mx, 16);
        step(1);
        // write landing exactly on a peak turning point
        while (!(cnt == 16 && cnt_up)) step(1);
        wr(1, 3);
        while (!(cnt == 0 && !cnt_up)) step(1);
        wr(2, 1);
        step(60);
        upd_mode = 2'b10; churn(300, 20);
        upd_mode = 2'b01; churn(300, 20);
        upd_mode = 2'b00; churn(200, 20);      // R11
        wr(5, 30); upd_mode = 2'b11; churn(200, 20);
        wr(3, 7); wr(5, 2); churn(200, 10);
        wr(6, 55); wr(7, 66); step(20);         // unmapped addresses (R4)
        wr(3, 0); step(60);                     // halt (R3)
        wr(3, 5); churn(150, 8);
        wr(4, 3); step(30);                     // polarity (R10)
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule